// File: doc/BRIEF.md
# Banked GPIO Pin Control Registers

This block is the register file of a general-purpose I/O controller whose pin count is a parameter and a multiple of 32. Software reaches it through a 32-bit register port. Each register kind is stored as a run of consecutive 32-bit words, one bit per pin. The block drives a per-pin output enable and output value. It samples the pin inputs through a two-stage synchroniser. It holds a 2-bit alternate-function selector for every pin. Rising-edge and falling-edge enables are exported to a separate edge-detection block. The edge status word is imported from that block, and writes to it are returned to it as clear pulses.

Output levels are never written directly. A write-one-to-set register raises pins and a write-one-to-clear register lowers them, so several agents can update different pins without a read-modify-write. The register port is a valid/ready request channel. `bus_ready` is low during reset and stays high afterwards, so the block never applies back-pressure once it is running. A request is accepted on any clock edge where `bus_valid` and `bus_ready` are both high. A read returns its data with a one-cycle `rd_valid` pulse. The response has no ready: the requester must take it in that cycle.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, `pin_oe`, `pin_out`, `pin_alt`, `rise_en`, `fall_en` and `edge_clr` are all zero, and `bus_ready` is high from the first edge after reset is released.
- R2: With W = NUM_PINS/32, byte address A (A%4 = 0) selects word w = A/4. Register kinds sit in this slot order: level 0, direction 1, set 2, clear 3, rising-enable 4, falling-enable 5, edge status 6, alternate function 7. Kind k < 7 covers words k*W to k*W+W-1. Pin p uses word p/32 of its kind, bit p%32.
- R3: The level words return the pin inputs after two register stages. A read accepted in the edge that first samples a new input value, or in the edge after it, returns the old value. A read one edge later returns the new value. Writes to level words change nothing.
- R4: A direction bit of 1 makes the pin an output (`pin_oe` high). A bit of 0 makes it an input. Direction words read back as written.
- R5: Writing a set word raises `pin_out` for every 1 bit and leaves every 0 bit unchanged. Set words always read as 0.
- R6: Writing a clear word lowers `pin_out` for every 1 bit and leaves every 0 bit unchanged. Clear words always read as 0.
- R7: Rising-enable and falling-enable words read back as written and drive `rise_en` and `fall_en` bit for bit.
- R8: Edge status words read the `edge_status` input. Writing one sets `edge_clr` for exactly one cycle, for the pins whose data bits are 1. `edge_clr` is zero in every other cycle.
- R9: The alternate-function region starts at word 7*W and spans 2*W words. Pin p is in word 7*W + p/16 at bits 2*(p%16)+1 down to 2*(p%16), driven on `pin_alt[2p+1:2p]`. The value 0 means plain GPIO. Alternate-function words read back as written.
- R10: A byte address at or beyond 36*W, or one that is not a multiple of 4, reads as 0 and ignores writes.
- R11: Every accepted read produces `rd_valid` high for exactly the following cycle, with `rd_data` holding the result. Writes produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register request present |
| bus_ready | output | 1 | Block can accept a request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 32 | Read data |
| pin_in | input | NUM_PINS | Raw pin input levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output value |
| pin_alt | output | 2*NUM_PINS | Per-pin alternate-function select |
| rise_en | output | NUM_PINS | Rising-edge enables to the edge block |
| fall_en | output | NUM_PINS | Falling-edge enables to the edge block |
| edge_status | input | NUM_PINS | Edge status from the edge block |
| edge_clr | output | NUM_PINS | One-cycle edge status clear pulses |

## Verification
The bench runs with 96 pins, so the number of words per kind is 3, which is not a power of two. A decoder that divides by shifting would place the set, clear and alternate-function blocks at the wrong addresses, and the readbacks would fail. The set and clear writes use patterns with mixed ones and zeros, and a set is also made in the second word. A design that overwrote the latch word, instead of only setting or clearing the selected bits, would show wrong `pin_out` bits. The bench probes the synchroniser at the exact edges where the new value must not yet appear and then must appear. It also tests the last alternate-function word, the first address beyond it, a misaligned write and a level write. These expose a missing stage, an off-by-one range limit, and writes that leak into other words.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned NUM_KINDS = 8;

  typedef enum logic [2:0] {
    KIND_LEVEL = 3'd0,
    KIND_DIR   = 3'd1,
    KIND_SET   = 3'd2,
    KIND_CLR   = 3'd3,
    KIND_RISE  = 3'd4,
    KIND_FALL  = 3'd5,
    KIND_EDGE  = 3'd6,
    KIND_ALT   = 3'd7
  } reg_kind_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

  // R3
  sync_second_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> stage2_q == $past(stage1_q));
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NREG   = 2,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o
);
  localparam int unsigned ALT_WORDS = 2 * NREG;
  localparam int unsigned ALT_BASE  = 7 * NREG;
  localparam int unsigned END_WORD  = ALT_BASE + ALT_WORDS;

  logic [31:0] word;
  assign word = 32'(addr_i[ADDR_W-1:2]);

  always_comb begin
    kind_o = KIND_LEVEL;
    idx_o  = '0;
    hit_o  = 1'b0;
    if (addr_i[1:0] == 2'b00) begin
      for (int k = 0; k < 7; k++) begin
        if (word >= 32'(k * NREG) && word < 32'((k + 1) * NREG)) begin
          kind_o = reg_kind_e'(3'(k));
          idx_o  = IDX_W'(word - 32'(k * NREG));
          hit_o  = 1'b1;
        end
      end
      if (word >= 32'(ALT_BASE) && word < 32'(END_WORD)) begin
        kind_o = KIND_ALT;
        idx_o  = IDX_W'(word - 32'(ALT_BASE));
        hit_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_pin_word.sv
module gpio_pin_word
  import gpio_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  reg_kind_e   kind_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] dir_o,
  output logic [31:0] out_o,
  output logic [31:0] rise_o,
  output logic [31:0] fall_o
);
  logic [31:0] dir_q, out_q, rise_q, fall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr_en_i) begin
      case (kind_i)
        KIND_DIR:  dir_q  <= wdata_i;
        KIND_SET:  out_q  <= out_q | wdata_i;
        KIND_CLR:  out_q  <= out_q & ~wdata_i;
        KIND_RISE: rise_q <= wdata_i;
        KIND_FALL: fall_q <= wdata_i;
        default:   ;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R5
  set_bits_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && kind_i == KIND_SET) |=> (out_q & $past(wdata_i)) == $past(wdata_i));
  // R5
  set_keeps_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && kind_i == KIND_SET) |=> ((out_q ^ $past(out_q)) & ~$past(wdata_i)) == 32'h0);
  // R6
  clr_bits_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && kind_i == KIND_CLR) |=> (out_q & $past(wdata_i)) == 32'h0);
  // R6
  clr_keeps_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && kind_i == KIND_CLR) |=> ((out_q ^ $past(out_q)) & ~$past(wdata_i)) == 32'h0);
  // R4
  dir_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && kind_i == KIND_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_alt_map.sv
module gpio_alt_map #(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [31:0]           wdata_i,
  output logic [2*NUM_PINS-1:0] pin_alt_o,
  output logic [31:0]           rd_word_o
);
  localparam int unsigned ALT_WORDS = NUM_PINS / 16;

  logic [31:0] alt_q [ALT_WORDS];

  for (genvar w = 0; w < ALT_WORDS; w++) begin : g_alt_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alt_q[w] <= '0;
      end else if (wr_en_i && idx_i == IDX_W'(w)) begin
        alt_q[w] <= wdata_i;
      end
    end
    assign pin_alt_o[w*32 +: 32] = alt_q[w];

    // R9
    alt_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && idx_i == IDX_W'(w)) |=> $stable(pin_alt_o[w*32 +: 32]));
  end

  always_comb begin
    rd_word_o = '0;
    for (int w = 0; w < ALT_WORDS; w++) begin
      if (idx_i == IDX_W'(w)) rd_word_o = alt_q[w];
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 96,
  parameter int unsigned ADDR_W   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  output logic                  bus_ready,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [2*NUM_PINS-1:0] pin_alt,
  output logic [NUM_PINS-1:0]   rise_en,
  output logic [NUM_PINS-1:0]   fall_en,
  input  logic [NUM_PINS-1:0]   edge_status,
  output logic [NUM_PINS-1:0]   edge_clr
);
  localparam int unsigned NREG  = NUM_PINS / WORD_BITS;
  localparam int unsigned IDX_W = (2 * NREG > 1) ? $clog2(2 * NREG) : 1;

  logic            ready_q;
  logic            accept;
  logic            do_wr;
  reg_kind_e       kind;
  logic [IDX_W-1:0] idx;
  logic            hit;
  logic [NUM_PINS-1:0] level_sync;
  logic [31:0]     alt_rd;
  logic [31:0]     rd_mux;
  logic            rd_valid_q;
  logic [31:0]     rd_data_q;
  logic [NUM_PINS-1:0] edge_clr_q;

  assign accept = bus_valid && ready_q;
  assign do_wr  = accept && bus_write && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign bus_ready = ready_q;

  gpio_addr_dec #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_dec (
    .addr_i (bus_addr),
    .kind_o (kind),
    .idx_o  (idx),
    .hit_o  (hit)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pin_in),
    .sync_o (level_sync)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_word
    logic word_wr;
    assign word_wr = do_wr && (kind != KIND_ALT) && (idx == IDX_W'(r));
    gpio_pin_word i_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (word_wr),
      .kind_i  (kind),
      .wdata_i (bus_wdata),
      .dir_o   (pin_oe[r*32 +: 32]),
      .out_o   (pin_out[r*32 +: 32]),
      .rise_o  (rise_en[r*32 +: 32]),
      .fall_o  (fall_en[r*32 +: 32])
    );
  end

  gpio_alt_map #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) i_alt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (do_wr && kind == KIND_ALT),
    .idx_i     (idx),
    .wdata_i   (bus_wdata),
    .pin_alt_o (pin_alt),
    .rd_word_o (alt_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      if (kind == KIND_ALT) begin
        rd_mux = alt_rd;
      end else begin
        for (int r = 0; r < NREG; r++) begin
          if (idx == IDX_W'(r)) begin
            case (kind)
              KIND_LEVEL: rd_mux = level_sync[r*32 +: 32];
              KIND_DIR:   rd_mux = pin_oe[r*32 +: 32];
              KIND_RISE:  rd_mux = rise_en[r*32 +: 32];
              KIND_FALL:  rd_mux = fall_en[r*32 +: 32];
              KIND_EDGE:  rd_mux = edge_status[r*32 +: 32];
              default:    rd_mux = '0;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      edge_clr_q <= '0;
    end else begin
      rd_valid_q <= accept && !bus_write;
      if (accept && !bus_write) rd_data_q <= rd_mux;
      edge_clr_q <= '0;
      if (do_wr && kind == KIND_EDGE) begin
        for (int r = 0; r < NREG; r++) begin
          if (idx == IDX_W'(r)) edge_clr_q[r*32 +: 32] <= bus_wdata;
        end
      end
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign edge_clr = edge_clr_q;

  // R11
  read_gets_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write) |=> rd_valid);
  // R11
  write_no_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_ready && !bus_write) |=> !rd_valid);
  // R10
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write && !hit) |=> rd_data == 32'h0);
  // R10
  miss_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_write && !hit) |=>
      $stable(pin_oe) && $stable(pin_out) && $stable(pin_alt) && $stable(rise_en) && $stable(fall_en));
  // R8
  edge_clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_ready && bus_write) |=> edge_clr == '0);
  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> bus_ready);
endmodule

// File: tb/test_gpio_bank_regs.sv
`timescale 1ns/1ps
module test_gpio_bank_regs;
  localparam int unsigned PINS   = 96;
  localparam int unsigned AW     = 10;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Word map for 96 pins (3 words per kind): level 0, dir 12, set 24, clr 36,
  // rise 48, fall 60, edge 72, alt 84..104, end 108.
  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'd12,  32'h0000_FFFF, 32'h0,          4'd4},  // R4 dir word0
    '{1'b0, 8'd12,  32'h0,         32'h0000_FFFF,  4'd4},  // R4
    '{1'b1, 8'd24,  32'hA5A5_A5A5, 32'h0,          4'd5},  // R5 set word0
    '{1'b0, 8'd24,  32'h0,         32'h0,          4'd5},  // R5 reads 0
    '{1'b1, 8'd36,  32'h0000_00FF, 32'h0,          4'd6},  // R6 clr word0
    '{1'b0, 8'd36,  32'h0,         32'h0,          4'd6},  // R6 reads 0
    '{1'b1, 8'd52,  32'h1234_5678, 32'h0,          4'd7},  // R7 rise word1
    '{1'b0, 8'd52,  32'h0,         32'h1234_5678,  4'd7},  // R7
    '{1'b1, 8'd68,  32'hCAFE_0001, 32'h0,          4'd7},  // R7 fall word2
    '{1'b0, 8'd68,  32'h0,         32'hCAFE_0001,  4'd7},  // R7
    '{1'b1, 8'd84,  32'h0000_000C, 32'h0,          4'd9},  // R9 pin1 alt=3
    '{1'b0, 8'd84,  32'h0,         32'h0000_000C,  4'd9},  // R9
    '{1'b1, 8'd104, 32'h8000_0000, 32'h0,          4'd9},  // R9 pin95 alt=2
    '{1'b0, 8'd104, 32'h0,         32'h8000_0000,  4'd9},  // R9
    '{1'b1, 8'd108, 32'hDEAD_BEEF, 32'h0,          4'd10}, // R10 beyond end
    '{1'b0, 8'd108, 32'h0,         32'h0,          4'd10}, // R10
    '{1'b1, 8'd13,  32'hFFFF_FFFF, 32'h0,          4'd10}, // R10 misaligned
    '{1'b0, 8'd12,  32'h0,         32'h0000_FFFF,  4'd10}, // R10 dir intact
    '{1'b1, 8'd4,   32'hFFFF_FFFF, 32'h0,          4'd3},  // R3 level write
    '{1'b0, 8'd16,  32'h0,         32'h0,          4'd2},  // R2 dir word1
    '{1'b1, 8'd28,  32'h0000_0001, 32'h0,          4'd2}   // R2 set pin 32
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0;
  logic bus_ready;
  logic bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [PINS-1:0] pin_in = '0;
  logic [PINS-1:0] pin_oe, pin_out, rise_en, fall_en, edge_clr;
  logic [2*PINS-1:0] pin_alt;
  logic [PINS-1:0] edge_status = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank_regs #(.NUM_PINS(PINS), .ADDR_W(AW)) i_gpio_bank_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .pin_alt(pin_alt), .rise_en(rise_en), .fall_en(fall_en),
    .edge_status(edge_status), .edge_clr(edge_clr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                    output logic [31:0] rdat, output logic rvld);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = wr;
    bus_addr  = AW'(addr);
    bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0;
    rdat = rd_data;
    rvld = rd_valid;
  endtask

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", 64'(pin_oe), 64'h0);
    check("R1 out", 64'(pin_out), 64'h0);
    check("R1 alt", 64'(|pin_alt), 64'h0);
    check("R1 rise/fall", 64'(|{rise_en, fall_en, edge_clr}), 64'h0);
    check("R1 ready", 64'(bus_ready), 64'h1);

    for (int i = 0; i < NVEC; i++) begin
      op(VECS[i].wr, VECS[i].addr, VECS[i].data, d, v);
      // R11 response only after reads
      check($sformatf("R11 valid vec%0d", i), 64'(v), 64'(!VECS[i].wr));
      if (!VECS[i].wr)
        check($sformatf("R%0d vec%0d", VECS[i].req, i), 64'(d), 64'(VECS[i].exp));
    end

    // R5 R6 latch after set A5A5A5A5 then clear 000000FF, plus pin 32 set (R2)
    check("R6 pin_out word0", 64'(pin_out[31:0]), 64'hA5A5_A500);
    check("R2 pin_out word1/2", 64'(pin_out[95:32]), 64'h1);
    check("R4 pin_oe", 64'(pin_oe[63:0]), 64'h0000_FFFF);
    check("R7 rise_en", 64'(rise_en[95:32]), 64'h1234_5678);
    check("R7 fall_en", 64'(fall_en[95:64]), 64'hCAFE_0001);
    check("R9 pin1 alt", 64'(pin_alt[3:0]), 64'hC);
    check("R9 pin95 alt", 64'(pin_alt[191:190]), 64'h2);
    check("R9 alt middle", 64'(|pin_alt[189:4]), 64'h0);

    // R3 synchroniser latency on level word2 (addr 8)
    @(negedge clk);
    pin_in = {32'h5A5A_0F0F, 64'h0};
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(8);
    @(negedge clk);
    check("R3 read same edge", 64'(rd_data), 64'h0);
    @(negedge clk);
    check("R3 read one edge later", 64'(rd_data), 64'h0);
    @(negedge clk);
    bus_valid = 1'b0;
    check("R3 read two edges later", 64'(rd_data), 64'h5A5A_0F0F);
    op(1'b0, 8'd4, 32'h0, d, v);
    check("R3 level word1 unaffected by write", 64'(d), 64'h0);

    // R8 edge status read and clear pulse
    edge_status = {64'h0, 32'h0000_0011};
    op(1'b0, 8'd72, 32'h0, d, v);
    check("R8 edge read", 64'(d), 64'h11);
    op(1'b1, 8'd76, 32'h0000_0300, d, v);
    check("R8 clr pulse", 64'(edge_clr[63:32]), 64'h300);
    check("R8 clr other words", 64'(edge_clr[31:0]), 64'h0);
    @(negedge clk);
    check("R8 clr one cycle", 64'(|edge_clr), 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule